// File: doc/BRIEF.md
# Key-Unlocked System Control Registers

This block holds a small set of chip-level control registers that software must not change by accident. Two of them are guarded: a device-configuration word (pin-routing choices, peripheral enables and a software-reset bit) and a clock-divider word. A guarded register accepts a write only if the write comes straight after software has written the unlock key to the key register. Any other write, including the guarded write itself, locks the block again. A read-only information word reports the chip revision in a fixed field.

The register port is a request/response pair. Requests use valid/ready. `req_ready` is held high, so the block never applies back-pressure, and a request is accepted on every clock edge where `req_valid` is high. Each accepted read produces exactly one response, one cycle later. The response has no ready signal, so the requester must always be able to take it. The configuration words drive output pins directly. Clearing and then setting the reset bit produces a one-cycle system-reset pulse. The pin multiplexers and clock dividers that use these outputs are outside the block.

Top module: `sysctl_keyreg`

## Requirements
- R1: After reset the block is locked, `cfg_devcfg` equals DEVCFG_RST, `cfg_clkdiv` equals CLKDIV_RST (both 0 by default), and `sw_reset_pulse` and `rsp_valid` are low.
- R2: A write of exactly the full word KEY (default 0x000000AA) to the key register (address 0) unlocks the block. While unlocked, reading address 0 returns 1; while locked it returns 0.
- R3: While unlocked, a write to device-config (address 1) or clock-divider (address 2) stores the write data, and the new value appears on the matching output after that clock edge.
- R4: While locked, a write to address 1 or 2 is ignored and the register keeps its previous value.
- R5: Every write to address 1, 2 or 3 relocks the block, so a second guarded write after a single unlock is ignored.
- R6: A write to the key register with any value other than KEY, including values that differ only in the upper bits, leaves the block locked.
- R7: Reads never change the lock state, so reads placed between the unlock write and the guarded write do not cancel the unlock.
- R8: Address 3 is read-only. It returns the revision parameter REV in bits [31:28] (0x30000000 by default) and zeros elsewhere. Writes to it leave its contents unchanged.
- R9: `sw_reset_pulse` is high for exactly one cycle, the cycle after device-config bit 31 changes from 0 to 1. It stays low when the bit stays at 1 or falls.
- R10: `req_ready` is always 1. A read accepted at one clock edge gives `rsp_valid` high for exactly the following cycle, with `rsp_rdata` holding the register's value at the time the read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word address: 0 key, 1 device-config, 2 clock-divider, 3 info |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W | Read response data |
| sw_reset_pulse | output | 1 | One-cycle system reset request |
| cfg_devcfg | output | DATA_W | Device-configuration word |
| cfg_clkdiv | output | DATA_W | Clock-divider word |

## Verification
The assertions check the following on every cycle:
- A locked guarded write leaves its register unchanged.
- An unlocked guarded write stores the write data.
- Every write that is not a key write relocks the block.
- A read keeps the lock state.
- The reset pulse lasts one cycle and occurs only on a rising reset bit.
- A response follows every read and nothing else.

The bench's scenarios cover the sequences that span several requests: unlocking and then reading back the key state, reads placed between the key write and the guarded write, near-miss key values, the read-only revision word, and reset-bit patterns that hold or fall without producing a pulse.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    A_KEY     = 2'd0,
    A_DEVCFG  = 2'd1,
    A_CLKDIV  = 2'd2,
    A_SYSINFO = 2'd3
  } reg_addr_e;
  localparam int N_GUARDED = 2;
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_00AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              is_key_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  logic open_q;

  // any write decides the next state; reads leave it alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     open_q <= 1'b0;
    else if (wr_en) open_q <= is_key_addr && (wdata == KEY);
  end

  assign unlocked = open_q;
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] DEVCFG_RST = '0,
  parameter logic [DATA_W-1:0] CLKDIV_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlocked,
  output logic [DATA_W-1:0] devcfg,
  output logic [DATA_W-1:0] clkdiv
);
  logic [DATA_W-1:0] word_q [N_GUARDED];

  for (genvar g = 0; g < N_GUARDED; g++) begin : g_guarded
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g + 1);
    localparam logic [DATA_W-1:0] MY_RST  = (g == 0) ? DEVCFG_RST : CLKDIV_RST;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[g] <= MY_RST;
      else if (wr_en && unlocked && (addr == MY_ADDR))
        word_q[g] <= wdata;
    end
  end

  assign devcfg = word_q[0];
  assign clkdiv = word_q[1];
endmodule

// File: rtl/sysctl_rstpulse.sv
module sysctl_rstpulse #(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LEVEL;
    else        prev_q <= level;
  end

  assign pulse = level & ~prev_q;
endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
  import sysctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY        = 32'h0000_00AA,
  parameter logic [DATA_W-1:0] DEVCFG_RST = '0,
  parameter logic [DATA_W-1:0] CLKDIV_RST = '0,
  parameter int SWRST_BIT = 31,
  parameter int REV_LSB   = 28,
  parameter int REV_W     = 4,
  parameter int REV       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sw_reset_pulse,
  output logic [DATA_W-1:0] cfg_devcfg,
  output logic [DATA_W-1:0] cfg_clkdiv
);
  localparam logic [DATA_W-1:0] SYSINFO_V =
    DATA_W'(REV_W'(REV)) << REV_LSB;

  logic wr_en, rd_en, lock_open;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = 1'b1;
  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  sysctl_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .is_key_addr(req_addr == A_KEY), .wdata(req_wdata),
    .unlocked(lock_open)
  );

  sysctl_regs #(.DATA_W(DATA_W), .DEVCFG_RST(DEVCFG_RST),
                .CLKDIV_RST(CLKDIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(req_addr),
    .wdata(req_wdata), .unlocked(lock_open),
    .devcfg(cfg_devcfg), .clkdiv(cfg_clkdiv)
  );

  sysctl_rstpulse #(.RST_LEVEL(DEVCFG_RST[SWRST_BIT])) u_pulse (
    .clk(clk), .rst_n(rst_n), .level(cfg_devcfg[SWRST_BIT]),
    .pulse(sw_reset_pulse)
  );

  always_comb begin
    unique case (req_addr)
      A_KEY:    rd_mux = DATA_W'(lock_open);
      A_DEVCFG: rd_mux = cfg_devcfg;
      A_CLKDIV: rd_mux = cfg_clkdiv;
      default:  rd_mux = SYSINFO_V;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sysctl_keyreg_chk.sv
module sysctl_keyreg_chk
  import sysctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SWRST_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              sw_reset_pulse,
  input logic [DATA_W-1:0] cfg_devcfg,
  input logic [DATA_W-1:0] cfg_clkdiv,
  input logic              lock_open
);
  logic wr, rd;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  a_r4_locked_devcfg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_DEVCFG && !lock_open) |=> $stable(cfg_devcfg));
  a_r4_locked_clkdiv: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_CLKDIV && !lock_open) |=> $stable(cfg_clkdiv));
  a_r3_open_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_DEVCFG && lock_open) |=> cfg_devcfg == $past(req_wdata));
  a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr != A_KEY) |=> !lock_open);
  a_r7_read_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> lock_open == $past(lock_open));
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_pulse |=> !sw_reset_pulse);
  a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_pulse |-> (cfg_devcfg[SWRST_BIT] && !$past(cfg_devcfg[SWRST_BIT])));
  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
endmodule

bind sysctl_keyreg sysctl_keyreg_chk #(.DATA_W(DATA_W), .SWRST_BIT(SWRST_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .sw_reset_pulse(sw_reset_pulse), .cfg_devcfg(cfg_devcfg),
  .cfg_clkdiv(cfg_clkdiv), .lock_open(lock_open)
);

// File: tb/sysctl_keyreg_bench.sv
module sysctl_keyreg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, sw_reset_pulse;
  logic [31:0] rsp_rdata, cfg_devcfg, cfg_clkdiv;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysctl_keyreg u_sysctl_keyreg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sw_reset_pulse(sw_reset_pulse), .cfg_devcfg(cfg_devcfg),
    .cfg_clkdiv(cfg_clkdiv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check("R10 rsp_valid after read", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    check("R10 rsp_valid single cycle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 devcfg reset", cfg_devcfg, 32'h0);
    check("R1 clkdiv reset", cfg_clkdiv, 32'h0);
    check("R1 pulse low", 32'(sw_reset_pulse), 32'd0);
    check("R1 rsp_valid low", 32'(rsp_valid), 32'd0);
    check("R10 ready high", 32'(req_ready), 32'd1);
    begin logic [31:0] v; rd(2'd0, v); check("R1 locked at reset", v, 32'd0); end
  endtask

  task automatic t_locked_write();
    logic [31:0] v;
    wr(2'd1, 32'h1234);
    check("R4 locked devcfg ignored", cfg_devcfg, 32'h0);
    wr(2'd2, 32'h77);
    rd(2'd2, v);
    check("R4 locked clkdiv ignored", v, 32'h0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    wr(2'd0, 32'hAA);
    rd(2'd0, v);
    check("R2 key reads 1 when open", v, 32'd1);
    wr(2'd1, 32'h55);
    check("R3 devcfg written", cfg_devcfg, 32'h55);
    rd(2'd0, v);
    check("R5 relocked after guarded write", v, 32'd0);
    wr(2'd1, 32'h66);
    check("R5 second write ignored", cfg_devcfg, 32'h55);
    rd(2'd1, v);
    check("R10 read data devcfg", v, 32'h55);
  endtask

  task automatic t_wrong_key();
    logic [31:0] v;
    wr(2'd0, 32'hAA);
    wr(2'd0, 32'hAB);
    rd(2'd0, v);
    check("R6 wrong key relocks", v, 32'd0);
    wr(2'd2, 32'h7);
    check("R6 clkdiv unchanged", cfg_clkdiv, 32'h0);
    wr(2'd0, 32'h1AA);
    wr(2'd2, 32'h9);
    check("R6 upper bits key rejected", cfg_clkdiv, 32'h0);
  endtask

  task automatic t_read_keeps();
    logic [31:0] v;
    wr(2'd0, 32'hAA);
    rd(2'd1, v);
    rd(2'd3, v);
    rd(2'd0, v);
    check("R7 reads keep unlock", v, 32'd1);
    wr(2'd2, 32'h20);
    check("R7 write after reads lands", cfg_clkdiv, 32'h20);
  endtask

  task automatic t_sysinfo();
    logic [31:0] v;
    rd(2'd3, v);
    check("R8 revision field", v, 32'h3000_0000);
    wr(2'd0, 32'hAA);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v);
    check("R8 info read-only", v, 32'h3000_0000);
    rd(2'd0, v);
    check("R5 info write relocks", v, 32'd0);
    wr(2'd1, 32'h99);
    check("R5 devcfg ignored after info write", cfg_devcfg, 32'h55);
  endtask

  task automatic t_swreset();
    wr(2'd0, 32'hAA); wr(2'd1, 32'h8000_0055);
    check("R9 pulse on rise", 32'(sw_reset_pulse), 32'd1);
    @(negedge clk);
    check("R9 pulse one cycle", 32'(sw_reset_pulse), 32'd0);
    wr(2'd0, 32'hAA); wr(2'd1, 32'h8000_0056);
    check("R9 no pulse when held", 32'(sw_reset_pulse), 32'd0);
    wr(2'd0, 32'hAA); wr(2'd1, 32'h0000_0055);
    check("R9 no pulse on fall", 32'(sw_reset_pulse), 32'd0);
    wr(2'd0, 32'hAA); wr(2'd1, 32'h8000_0000);
    check("R9 pulse on second rise", 32'(sw_reset_pulse), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_locked_write();
    t_unlock();
    t_wrong_key();
    t_read_keeps();
    t_sysinfo();
    t_swreset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule